// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

The allocator takes decoded internal operations one at a time from a valid/ready stream and packs them, strictly in program order, into dispatch groups of five slots. Every operation carries a three-bit class code and a tag. The class decides which slots the operation may take. Single ops take one slot, split ops take two neighbouring slots, branches take only the last slot, and some ops must either open a group or fill its first four slots. The slot an operation lands in fixes the execution unit instance it is bound to.

A group is built in internal registers. It is emitted as one output word when the next operation cannot legally join it, or when no operation is offered while the group holds something. When a non-fitting operation closes a group, that operation opens the next group at the same clock edge. The output is a single registered group with a downstream ready. While that group waits, any operation that would need a close is held back, so nothing is dropped and nothing is reordered.

Top module: `dispatch_group_alloc`

## Requirements
- R1: After reset `grp_vld_o` and every bit of `slot_vld_o` are 0, and `op_rdy_o` is 1 while the output is empty.
- R2: Slots are numbered 0 to 4. Each accepted operation is placed at or after the first free slot of the open group, never below a slot that is already taken, so the tags of one group rise with slot index.
- R3: Class codes 0 (integer), 1 (load/store), 2 (floating point) and 7 (other single) take one slot, the first free one. They may use only slots 0 to 3.
- R4: `slot_inst_o[s]` is 1 for a valid slot 1 or 2. It is 0 for a valid slot 0, 3 or 4, and for any invalid slot.
- R5: Class code 3 (split op) takes the first free slot and the slot above it, with the same tag in both. It fits only if the first free slot is 0, 1 or 2.
- R6: Class code 4 (branch) takes slot 4 only. Every unused slot below it stays invalid, and no later operation joins that group.
- R7: Class code 5 (serialising op) fits only an empty group, where it takes slots 0 to 3 with one tag. A branch may still follow it in slot 4.
- R8: Class code 6 (first-only op) fits only an empty group, where it takes slot 0.
- R9: When the offered operation does not fit, the open group is emitted. At that same edge the operation is placed in a fresh group, so a back-to-back stream loses no cycle.
- R10: When `op_vld_i` is low and the open group holds anything, that group is emitted.
- R11: While `grp_vld_o` is 1 and `grp_rdy_i` is 0, all group outputs hold. `op_rdy_o` goes low only in this state, and only when the offered operation would need a close.
- R12: An invalid slot reports tag 0 and class 0. When `grp_vld_o` is 0, all slot outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_vld_i | input | 1 | Operation offered |
| op_rdy_o | output | 1 | Operation accepted this cycle |
| op_cls_i | input | 3 | Operation class code |
| op_tag_i | input | TAG_W | Operation tag |
| grp_vld_o | output | 1 | Emitted group valid |
| grp_rdy_i | input | 1 | Downstream takes the group |
| slot_vld_o | output | 5 | Per-slot valid |
| slot_tag_o | output | 5*TAG_W | Per-slot tag, slot s at bits s*TAG_W |
| slot_cls_o | output | 15 | Per-slot class, slot s at bits 3*s |
| slot_inst_o | output | 5 | Per-slot unit instance |

## Verification
Two things can happen at the same clock edge: a full group is handed downstream, and the operation that could not join it opens the next group. The bench forces this with back-to-back streams in which one op overflows the group, for example a split op arriving at slot 3 or a serialising op arriving at a non-empty group. Downstream ready is randomised during these streams, and in one case it is held low so the close has to wait. Each emitted group is compared slot by slot with a packing of the same stream worked out in the bench from the class rules. The bench also checks that `op_rdy_o` drops, and that the waiting group stays stable, while ready is held low.

// File: rtl/dga_pkg.sv
package dga_pkg;
  localparam int NSLOT = 5;
  localparam int CLS_W = 3;
  localparam int PTR_W = 3;

  localparam logic [CLS_W-1:0] CLS_INT   = 3'd0;
  localparam logic [CLS_W-1:0] CLS_LSU   = 3'd1;
  localparam logic [CLS_W-1:0] CLS_FPU   = 3'd2;
  localparam logic [CLS_W-1:0] CLS_PAIR  = 3'd3;
  localparam logic [CLS_W-1:0] CLS_BR    = 3'd4;
  localparam logic [CLS_W-1:0] CLS_SOLO  = 3'd5;
  localparam logic [CLS_W-1:0] CLS_FIRST = 3'd6;
  localparam logic [CLS_W-1:0] CLS_MISC  = 3'd7;

  // unit instance bound to a slot position
  function automatic logic slot_inst(int unsigned s);
    return (s == 1) || (s == 2);
  endfunction
endpackage

// File: rtl/dga_fit.sv
module dga_fit
  import dga_pkg::*;
(
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic             fits_o,
  output logic [NSLOT-1:0] take_o,
  output logic [PTR_W-1:0] nxt_o
);
  always_comb begin
    fits_o = 1'b0;
    take_o = '0;
    nxt_o  = ptr_i;
    unique case (cls_i)
      CLS_PAIR: begin
        fits_o = ptr_i < 3'd3;
        take_o = 5'b00011 << ptr_i;
        nxt_o  = ptr_i + 3'd2;
      end
      CLS_BR: begin
        fits_o = ptr_i < 3'd5;
        take_o = 5'b10000;
        nxt_o  = 3'd5;
      end
      CLS_SOLO: begin
        fits_o = ptr_i == 3'd0;
        take_o = 5'b01111;
        nxt_o  = 3'd4;
      end
      CLS_FIRST: begin
        fits_o = ptr_i == 3'd0;
        take_o = 5'b00001;
        nxt_o  = 3'd1;
      end
      default: begin
        fits_o = ptr_i < 3'd4;
        take_o = 5'b00001 << ptr_i;
        nxt_o  = ptr_i + 3'd1;
      end
    endcase
  end

  always_comb begin
    if (fits_o) assert_in_order_R2: assert (nxt_o > ptr_i);
  end
endmodule

// File: rtl/dga_slot.sv
module dga_slot
  import dga_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [CLS_W-1:0] cls_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      tag_o <= '0;
      cls_o <= '0;
    end else if (wr_i) begin
      vld_o <= 1'b1;
      tag_o <= tag_i;
      cls_o <= cls_i;
    end else if (clr_i) begin
      vld_o <= 1'b0;
      tag_o <= '0;
      cls_o <= '0;
    end
  end
endmodule

// File: rtl/dispatch_group_alloc.sv
module dispatch_group_alloc
  import dga_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   op_vld_i,
  output logic                   op_rdy_o,
  input  logic [2:0]             op_cls_i,
  input  logic [TAG_W-1:0]       op_tag_i,
  output logic                   grp_vld_o,
  input  logic                   grp_rdy_i,
  output logic [4:0]             slot_vld_o,
  output logic [5*TAG_W-1:0]     slot_tag_o,
  output logic [14:0]            slot_cls_o,
  output logic [4:0]             slot_inst_o
);
  localparam int TAGS_W = NSLOT * TAG_W;
  localparam int CLSS_W = NSLOT * CLS_W;

  logic [PTR_W-1:0]  ptr_q;
  logic              fits_c, fits_n;
  logic [NSLOT-1:0]  take_c, take_n, take;
  logic [PTR_W-1:0]  nxt_c, nxt_n;
  logic [NSLOT-1:0]  cur_vld;
  logic [TAGS_W-1:0] cur_tag;
  logic [CLSS_W-1:0] cur_cls;
  logic              need_close, can_emit, do_close, acc;

  logic              grp_vld_q;
  logic [NSLOT-1:0]  out_vld_q, out_inst_q, inst_d;
  logic [TAGS_W-1:0] out_tag_q;
  logic [CLSS_W-1:0] out_cls_q;

  dga_fit u_fit_cur (.ptr_i(ptr_q), .cls_i(op_cls_i), .fits_o(fits_c), .take_o(take_c), .nxt_o(nxt_c));
  dga_fit u_fit_new (.ptr_i(3'd0),  .cls_i(op_cls_i), .fits_o(fits_n), .take_o(take_n), .nxt_o(nxt_n));

  assign can_emit   = !grp_vld_q || grp_rdy_i;
  assign need_close = (ptr_q != '0) && !(op_vld_i && fits_c);
  assign op_rdy_o   = !need_close || can_emit;
  assign do_close   = need_close && can_emit;
  assign acc        = op_vld_i && op_rdy_o;
  assign take       = do_close ? take_n : take_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (acc)      ptr_q <= do_close ? nxt_n : nxt_c;
    else if (do_close) ptr_q <= '0;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    dga_slot #(.TAG_W(TAG_W)) u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (do_close),
      .wr_i  (acc && take[s]),
      .tag_i (op_tag_i),
      .cls_i (op_cls_i),
      .vld_o (cur_vld[s]),
      .tag_o (cur_tag[s*TAG_W +: TAG_W]),
      .cls_o (cur_cls[s*CLS_W +: CLS_W])
    );
    assign inst_d[s] = cur_vld[s] && slot_inst(s);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_vld_q  <= 1'b0;
      out_vld_q  <= '0;
      out_tag_q  <= '0;
      out_cls_q  <= '0;
      out_inst_q <= '0;
    end else if (can_emit) begin
      grp_vld_q  <= do_close;
      out_vld_q  <= do_close ? cur_vld : '0;
      out_tag_q  <= do_close ? cur_tag : '0;
      out_cls_q  <= do_close ? cur_cls : '0;
      out_inst_q <= do_close ? inst_d  : '0;
    end
  end

  assign grp_vld_o   = grp_vld_q;
  assign slot_vld_o  = out_vld_q;
  assign slot_tag_o  = out_tag_q;
  assign slot_cls_o  = out_cls_q;
  assign slot_inst_o = out_inst_q;

  assert_stall_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_vld_o && !grp_rdy_i |=> grp_vld_o && $stable(slot_vld_o) && $stable(slot_tag_o) && $stable(slot_cls_o));
  assert_rdy_low_only_stalled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_rdy_o |-> grp_vld_o && !grp_rdy_i);
  assert_empty_group_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_vld_o |-> slot_vld_o == '0);
  assert_solo_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_vld_o[0] && slot_cls_o[2:0] == CLS_SOLO |-> slot_vld_o[3:0] == 4'hf
      && slot_tag_o[TAG_W +: TAG_W] == slot_tag_o[0 +: TAG_W]);
  assert_last_slot_branch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_vld_o[4] |-> slot_cls_o[14:12] == CLS_BR);

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    if (s < NSLOT - 1) begin : g_br
      assert_branch_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_vld_o[s] |-> slot_cls_o[s*CLS_W +: CLS_W] != CLS_BR);
    end
    if (s > 0) begin : g_first
      assert_first_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_vld_o[s] |-> slot_cls_o[s*CLS_W +: CLS_W] != CLS_FIRST);
    end
  end
endmodule

// File: tb/dispatch_group_alloc_test.sv
`timescale 1ns/1ps
module dispatch_group_alloc_test;
  localparam int TAG_W = 6;
  localparam int MAXG  = 2048;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic op_vld_i = 1'b0, grp_rdy_i = 1'b0;
  logic [2:0] op_cls_i = '0;
  logic [TAG_W-1:0] op_tag_i = '0;
  logic op_rdy_o, grp_vld_o;
  logic [4:0] slot_vld_o, slot_inst_o;
  logic [5*TAG_W-1:0] slot_tag_o;
  logic [14:0] slot_cls_o;

  dispatch_group_alloc #(.TAG_W(TAG_W)) uut (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic [4:0]       ev [MAXG];
  logic [TAG_W-1:0] et [MAXG][5];
  logic [2:0]       ec [MAXG][5];
  string            el [MAXG];
  int n_exp = 0, n_got = 0;

  int mptr = 0;
  logic [4:0]       mv;
  logic [TAG_W-1:0] mt [5];
  logic [2:0]       mc [5];
  string lbl = "R1";
  logic [TAG_W-1:0] tag_ctr = '0;
  bit hold_low = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mclear();
    mptr = 0; mv = '0;
    for (int s = 0; s < 5; s++) begin mt[s] = '0; mc[s] = '0; end
  endtask

  task automatic mpush(string l);
    ev[n_exp] = mv;
    for (int s = 0; s < 5; s++) begin et[n_exp][s] = mt[s]; ec[n_exp][s] = mc[s]; end
    el[n_exp] = l;
    n_exp++;
    mclear();
  endtask

  // slot rules from the requirements: returns first slot, count, new pointer
  task automatic mfit(int p, logic [2:0] c, output bit ok, output int lo, output int n, output int np);
    case (c)
      3'd3: begin ok = p <= 2;  lo = p; n = 2; np = p + 2; end
      3'd4: begin ok = p <= 4;  lo = 4; n = 1; np = 5;     end
      3'd5: begin ok = p == 0;  lo = 0; n = 4; np = 4;     end
      3'd6: begin ok = p == 0;  lo = 0; n = 1; np = 1;     end
      default: begin ok = p <= 3; lo = p; n = 1; np = p + 1; end
    endcase
  endtask

  task automatic mplace(logic [2:0] c, logic [TAG_W-1:0] t);
    bit ok; int lo, n, np;
    mfit(mptr, c, ok, lo, n, np);
    if (!ok) begin
      mpush(lbl);
      mfit(0, c, ok, lo, n, np);
    end
    for (int s = lo; s < lo + n; s++) begin mv[s] = 1'b1; mt[s] = t; mc[s] = c; end
    mptr = np;
  endtask

  task automatic compare();
    bit okv, okd, oki;
    int g;
    g = n_got;
    okv = slot_vld_o == ev[g];
    okd = 1; oki = 1;
    for (int s = 0; s < 5; s++) begin
      if (slot_tag_o[s*TAG_W +: TAG_W] != et[g][s] || slot_cls_o[s*3 +: 3] != ec[g][s]) okd = 0;
      if (slot_inst_o[s] != (ev[g][s] && (s == 1 || s == 2))) oki = 0;
    end
    chk(okv, el[g], int'(slot_vld_o), int'(ev[g]));
    chk(okd, {el[g], " R12 slot content"}, int'(slot_tag_o), et[g][0]);
    chk(oki, "R4 unit instance", int'(slot_inst_o), g);
    n_got++;
  endtask

  // called just after a negedge; inputs already driven
  task automatic step(output bit acc);
    grp_rdy_i = hold_low ? 1'b0 : (($urandom % 10) < 7);
    #1;
    acc = op_vld_i && op_rdy_o;
    if (grp_vld_o && grp_rdy_i) begin
      if (n_got < n_exp) compare();
      else chk(0, "R9 unexpected group", n_got, n_exp);
    end
    @(negedge clk_i);
  endtask

  task automatic send(logic [2:0] c);
    bit acc;
    op_vld_i = 1'b1; op_cls_i = c; op_tag_i = tag_ctr;
    do step(acc); while (!acc);
    mplace(c, tag_ctr);
    tag_ctr++;
  endtask

  task automatic flush(string l);
    bit acc;
    op_vld_i = 1'b0;
    if (mptr > 0) mpush(l);
    while (n_got < n_exp) step(acc);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_got, n_exp);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    mclear();
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(grp_vld_o == 0, "R1 grp_vld", grp_vld_o, 0);
    chk(slot_vld_o == 0, "R1 slot_vld", slot_vld_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(op_rdy_o == 1, "R1 op_rdy", op_rdy_o, 1);

    lbl = "R2"; send(0); send(1); send(2); send(7); flush("R10");
    lbl = "R3"; for (int i = 0; i < 5; i++) send(i[2:0] == 3 ? 3'd0 : 3'd1); flush("R10");
    lbl = "R5"; send(0); send(0); send(0); send(3); send(3); send(3); flush("R10");
    lbl = "R6"; send(0); send(4); send(0); send(4); send(4); flush("R10");
    lbl = "R7"; send(0); send(5); send(4); send(5); send(5); flush("R10");
    lbl = "R8"; send(0); send(6); send(6); send(0); send(6); flush("R10");
    lbl = "R9"; send(3); send(3); send(0); send(2); send(3); send(1); send(5); flush("R10");

    // R11: close needed while the emitted group is held
    lbl = "R11";
    hold_low = 1;
    for (int i = 0; i < 8; i++) send(3'd0);
    op_vld_i = 1'b1; op_cls_i = 3'd1; op_tag_i = tag_ctr;
    for (int k = 0; k < 3; k++) begin
      step(acc);
      chk(!acc && !op_rdy_o, "R11 op_rdy low in stall", op_rdy_o, 0);
      chk(grp_vld_o && slot_tag_o[TAG_W-1:0] == et[n_got][0], "R11 group held",
          int'(slot_tag_o[TAG_W-1:0]), et[n_got][0]);
    end
    hold_low = 0;
    do step(acc); while (!acc);
    mplace(3'd1, tag_ctr); tag_ctr++;
    flush("R10");

    // random streams
    lbl = "R9";
    for (int b = 0; b < 80; b++) begin
      int len;
      len = 1 + int'($urandom % 14);
      for (int i = 0; i < len; i++) send(3'($urandom % 8));
      flush("R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule